// File: doc/BRIEF.md
# Dual Decade Counter with Selectable Chaining

The block holds two independent decade counters. Each counter is built from two sections: a divide-by-2 section that owns output bit Q0, and a divide-by-5 section that owns bits Q3..Q1 as a 3-bit binary value stepping 0, 1, 2, 3, 4 and back to 0. Each section has its own count input. A section advances once on each high-to-low transition of that input. A rising transition or a steady level does nothing.

A per-counter mode bit selects how the two sections are chained. In BCD mode a falling Q0 steps the divide-by-5 section, so the four bits count 0..9 in binary. In bi-quinary mode the divide-by-5 wrap from 4 to 0 toggles Q0, so Q0 is a square wave at one tenth of the divide-by-5 input rate.

Everything runs on one system clock. Count inputs pass through a synchronizer and an edge detector. Each counter has an active-high asynchronous clear that acts on its own four bits only. Division by 20, 50 or 100 comes from wiring one counter's output to the other counter's count input outside the block.

Top module: `dual_decade_counter`

## Requirements
- R1: While rst_ni is low, all bits of q_o are 0.
- R2: A high level on clr_i[n] forces q_o[4n+3:4n] to 0 without waiting for a clock edge, and leaves the other counter's bits unchanged. Raising both clears all eight bits.
- R3: A section advances once per high-to-low transition of its count input. The new value appears on the second clk_i rising edge after the first edge that samples the input low.
- R4: A low-to-high transition, or a level held high or low, on a count input leaves the count unchanged.
- R5: The divide-by-5 field q_o[4n+3:4n+1] counts 0,1,2,3,4 in binary and then wraps to 0. Q0 of counter n is q_o[4n].
- R6: With mode_i[n]=0 (BCD), tick2_i[n] drives Q0, each 1-to-0 step of Q0 advances the divide-by-5 field in the same cycle, q_o[4n+3:4n] counts 0..9 and wraps, and tick5_i[n] is ignored.
- R7: With mode_i[n]=1 (bi-quinary), tick5_i[n] drives the divide-by-5 field, each 4-to-0 wrap toggles Q0 in the same cycle, and tick2_i[n] is ignored. Q0 stays high for five tick5 falls and low for five.
- R8: Q0 divides its input by 2. Q3 falls once per 5 divide-by-5 steps. In BCD mode Q3 falls once per 10 tick2 falls, and in bi-quinary mode Q0 falls once per 10 tick5 falls.
- R9: A count-input falling edge that happens while that counter is cleared is not counted after the clear is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; count inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset for both counters |
| clr_i | input | 2 | Asynchronous active-high clear, bit n for counter n |
| mode_i | input | 2 | Chaining per counter: 0 = BCD, 1 = bi-quinary |
| tick2_i | input | 2 | Count input of the divide-by-2 section of counter n |
| tick5_i | input | 2 | Count input of the divide-by-5 section of counter n |
| q_o | output | 8 | Counter n outputs in bits 4n+3..4n, Q0 in the low bit |

## Verification
A count input that goes low before rising edge k is captured at edge k, reaches the second synchronizer stage at k+1, and changes q_o at k+2. A chained carry lands in that same cycle. A clear changes q_o at once, with no edge needed. The inputs change on the falling clock edge. The reference model takes in the inputs on each rising edge with the same two-flop-plus-previous-sample history, and q_o is compared a quarter period after every rising edge. The explicit latency check samples at edges k, k+1 and k+2 and expects the old, old and new values. The clear checks sample before the next rising edge.

// File: rtl/dqc_pkg.sv
package dqc_pkg;
  typedef enum logic {CHAIN_BCD = 1'b0, CHAIN_BIQ = 1'b1} chain_e;
  localparam int LO_MOD = 2;
  localparam int HI_MOD = 5;
endpackage

// File: rtl/dqc_edge_detect.sv
module dqc_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic raw_i,
  output logic fall_o
);
  // synchronizer stages plus one previous-sample stage
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) pipe_q <= '0;
    else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], raw_i};
  end

  assign fall_o = pipe_q[SYNC_STAGES] & ~pipe_q[SYNC_STAGES-1];

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (arst_i)
    fall_o |=> !fall_o)
    else $error("edge detector fired two cycles in a row");
endmodule

// File: rtl/dqc_mod_counter.sv
module dqc_mod_counter #(
  parameter int MOD = 5,
  localparam int W = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic         clk_i,
  input  logic         arst_i,
  input  logic         step_i,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i)          val_o <= '0;
    else if (step_i) begin
      if (val_o == W'(MOD-1)) val_o <= '0;
      else                    val_o <= val_o + W'(1);
    end
  end

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (arst_i)
    !step_i |=> $stable(val_o))
    else $error("section moved without a step");

  assert_range_R5: assert property (@(posedge clk_i) disable iff (arst_i)
    val_o <= W'(MOD-1))
    else $error("section value out of range");
endmodule

// File: rtl/dqc_decade.sv
module dqc_decade
  import dqc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       arst_i,
  input  chain_e     mode_i,
  input  logic       tick2_i,
  input  logic       tick5_i,
  output logic [3:0] q_o
);
  localparam int HW = $clog2(HI_MOD);

  logic          fall2, fall5;
  logic          step2, step5;
  logic          bcd_carry, biq_carry;
  logic          q0;
  logic [HW-1:0] q5;

  dqc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) i_edge2 (
    .clk_i(clk_i), .arst_i(arst_i), .raw_i(tick2_i), .fall_o(fall2));
  dqc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) i_edge5 (
    .clk_i(clk_i), .arst_i(arst_i), .raw_i(tick5_i), .fall_o(fall5));

  // carries come from the raw edges so the mode muxes form no loop
  assign bcd_carry = fall2 & q0;
  assign biq_carry = fall5 & (q5 == HW'(HI_MOD-1));

  assign step2 = (mode_i == CHAIN_BIQ) ? biq_carry : fall2;
  assign step5 = (mode_i == CHAIN_BIQ) ? fall5     : bcd_carry;

  dqc_mod_counter #(.MOD(LO_MOD)) i_lo (
    .clk_i(clk_i), .arst_i(arst_i), .step_i(step2), .val_o(q0));
  dqc_mod_counter #(.MOD(HI_MOD)) i_hi (
    .clk_i(clk_i), .arst_i(arst_i), .step_i(step5), .val_o(q5));

  assign q_o = {q5, q0};

  assert_bcd_chain_R6: assert property (@(posedge clk_i) disable iff (arst_i)
    ($past(mode_i) == CHAIN_BCD && q5 != $past(q5)) |-> ($past(q0) && !q0))
    else $error("BCD: high section moved without Q0 falling");

  assert_biq_chain_R7: assert property (@(posedge clk_i) disable iff (arst_i)
    ($past(mode_i) == CHAIN_BIQ && q0 != $past(q0)) |->
      ($past(q5) == HW'(HI_MOD-1) && q5 == '0))
    else $error("bi-quinary: Q0 toggled without a high-section wrap");
endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
  import dqc_pkg::*;
#(
  parameter int NUM_CNT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CNT-1:0]   clr_i,
  input  logic [NUM_CNT-1:0]   mode_i,
  input  logic [NUM_CNT-1:0]   tick2_i,
  input  logic [NUM_CNT-1:0]   tick5_i,
  output logic [4*NUM_CNT-1:0] q_o
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic arst;
    assign arst = ~rst_ni | clr_i[g];

    dqc_decade #(.SYNC_STAGES(SYNC_STAGES)) i_decade (
      .clk_i  (clk_i),
      .arst_i (arst),
      .mode_i (chain_e'(mode_i[g])),
      .tick2_i(tick2_i[g]),
      .tick5_i(tick5_i[g]),
      .q_o    (q_o[4*g +: 4])
    );

    assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[g] |-> q_o[4*g +: 4] == 4'd0)
      else $error("counter %0d not held clear", g);
  end
endmodule

// File: tb/test_dual_decade_counter.sv
module test_dual_decade_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] clr_i = '0, mode_i = '0, tick2_i = '0, tick5_i = '0;
  logic [7:0] q_o;

  dual_decade_counter i_dual_decade_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .mode_i(mode_i),
    .tick2_i(tick2_i), .tick5_i(tick5_i), .q_o(q_o));

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int    n_checks = 0, n_errors = 0;
  bit    finished = 0;
  string tag = "R1";

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: input history and integer digit counts
  int d2[2], d5[2];
  bit [2:0] h2[2], h5[2];

  always @(posedge clk_i) begin
    for (int n = 0; n < 2; n++) begin
      if (!rst_ni || clr_i[n]) begin
        d2[n] = 0; d5[n] = 0; h2[n] = 0; h5[n] = 0;
      end else begin
        bit f2, f5;
        f2 = h2[n][2] & ~h2[n][1];
        f5 = h5[n][2] & ~h5[n][1];
        if (mode_i[n] == 1'b0) begin
          if (f2) begin
            if (d2[n] == 1) begin d2[n] = 0; d5[n] = (d5[n] + 1) % 5; end
            else d2[n] = 1;
          end
        end else if (f5) begin
          if (d5[n] == 4) begin d5[n] = 0; d2[n] = 1 - d2[n]; end
          else d5[n] = d5[n] + 1;
        end
        h2[n] = {h2[n][1:0], tick2_i[n]};
        h5[n] = {h5[n][1:0], tick5_i[n]};
      end
    end
  end

  function automatic int model_q(int n);
    if (!rst_ni || clr_i[n]) return 0;
    return d5[n] * 2 + d2[n];
  endfunction

  // compare a quarter period after every rising edge
  always begin
    @(posedge clk_i);
    #(CLK_PERIOD/4);
    if (!finished)
      for (int n = 0; n < 2; n++)
        check(tag, $sformatf("model compare ctr%0d", n), int'(q_o[4*n +: 4]), model_q(n));
  end

  // fall counters for the ratio checks
  bit       meas = 0;
  logic [7:0] prev_q = '0;
  int f_c0q0 = 0, f_c0q3 = 0, f_c1q0 = 0, f_c1q3 = 0;
  always @(negedge clk_i) begin
    if (meas) begin
      if (prev_q[0] && !q_o[0]) f_c0q0++;
      if (prev_q[3] && !q_o[3]) f_c0q3++;
      if (prev_q[4] && !q_o[4]) f_c1q0++;
      if (prev_q[7] && !q_o[7]) f_c1q3++;
    end
    prev_q = q_o;
  end

  task automatic pulse2(int n);
    @(negedge clk_i) tick2_i[n] = 1'b1;
    repeat (3) @(negedge clk_i);
    tick2_i[n] = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic pulse5(int n);
    @(negedge clk_i) tick5_i[n] = 1'b1;
    repeat (3) @(negedge clk_i);
    tick5_i[n] = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] saved;
    repeat (3) @(negedge clk_i);
    check("R1", "q_o in reset", int'(q_o), 0);
    rst_ni = 1'b1;
    mode_i = 2'b10;  // ctr0 BCD, ctr1 bi-quinary
    repeat (2) @(negedge clk_i);

    // R3 latency: old at edges k and k+1, new at k+2
    tag = "R3";
    tick2_i[0] = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R4", "rise leaves count", int'(q_o[3:0]), 0);
    tick2_i[0] = 1'b0;
    @(posedge clk_i); #(CLK_PERIOD/4);
    check("R3", "edge k old value", int'(q_o[3:0]), 0);
    @(posedge clk_i); #(CLK_PERIOD/4);
    check("R3", "edge k+1 old value", int'(q_o[3:0]), 0);
    @(posedge clk_i); #(CLK_PERIOD/4);
    check("R3", "edge k+2 new value", int'(q_o[3:0]), 1);
    @(negedge clk_i);

    tag = "R4";
    tick2_i[0] = 1'b1;
    repeat (6) @(negedge clk_i);
    check("R4", "held high no count", int'(q_o[3:0]), 1);
    tick2_i[0] = 1'b0;
    repeat (6) @(negedge clk_i);
    check("R4", "held low counts once", int'(q_o[3:0]), 2);

    tag = "R6";
    for (int i = 0; i < 7; i++) pulse2(0);
    check("R6", "BCD reaches 9", int'(q_o[3:0]), 9);
    pulse2(0);
    check("R6", "BCD wraps to 0", int'(q_o[3:0]), 0);
    pulse2(0);
    for (int i = 0; i < 3; i++) pulse5(0);
    check("R6", "tick5 ignored in BCD", int'(q_o[3:0]), 1);

    tag = "R5";
    for (int i = 0; i < 4; i++) pulse5(1);
    check("R5", "high field at 4", int'(q_o[7:5]), 4);
    check("R5", "Q0 low before wrap", int'(q_o[4]), 0);
    pulse5(1);
    tag = "R7";
    check("R5", "high field wraps", int'(q_o[7:5]), 0);
    check("R7", "wrap toggles Q0", int'(q_o[4]), 1);
    pulse2(1); pulse2(1);
    check("R7", "tick2 ignored in bi-quinary", int'(q_o[7:4]), 1);
    for (int i = 0; i < 4; i++) pulse5(1);
    check("R7", "Q0 still high after 9 falls", int'(q_o[4]), 1);
    pulse5(1);
    check("R7", "Q0 low after 10 falls", int'(q_o[4]), 0);
    pulse5(1);

    tag = "R2";
    pulse2(0); pulse2(0);
    saved = q_o[7:4];
    @(negedge clk_i) clr_i[0] = 1'b1;
    #1;
    check("R2", "ctr0 cleared at once", int'(q_o[3:0]), 0);
    check("R2", "ctr1 untouched", int'(q_o[7:4]), int'(saved));
    @(negedge clk_i) clr_i[0] = 1'b0;
    pulse2(0);
    check("R2", "ctr0 counts after clear", int'(q_o[3:0]), 1);

    tag = "R9";
    @(negedge clk_i) clr_i[1] = 1'b1; tick5_i[1] = 1'b1;
    repeat (3) @(negedge clk_i);
    tick5_i[1] = 1'b0;
    repeat (3) @(negedge clk_i);
    clr_i[1] = 1'b0;
    repeat (6) @(negedge clk_i);
    check("R9", "edge during clear dropped", int'(q_o[7:4]), 0);

    tag = "R8";
    @(negedge clk_i) clr_i = 2'b11;
    #1;
    check("R2", "both clears zero all bits", int'(q_o), 0);
    @(negedge clk_i) clr_i = 2'b00;
    repeat (2) @(negedge clk_i);
    meas = 1;
    fork
      for (int i = 0; i < 100; i++) pulse2(0);
      for (int i = 0; i < 50; i++) pulse5(1);
    join
    repeat (2) @(negedge clk_i);
    meas = 0;
    check("R8", "BCD Q0 falls per 100", f_c0q0, 50);
    check("R8", "BCD Q3 falls per 100", f_c0q3, 10);
    check("R8", "bi-quinary Q3 falls per 50", f_c1q3, 10);
    check("R8", "bi-quinary Q0 falls per 50", f_c1q0, 5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule